// File: doc/BRIEF.md
# Detented Rotary Encoder Step Decoder

This block takes the two raw contact lines of a mechanical rotary encoder with detents and produces one clock-wide pulse for each full clockwise or counter-clockwise detent-to-detent click. Each contact line first passes through its own flip-flop synchronizer. The synchronized pair is then inverted and mapped from Gray code to plain binary, so that clockwise rotation counts upward. A three-bit signed tracking counter follows the binary position between detents. A pulse is emitted only when the shaft comes back to a detent after three consistent quarter steps in the same direction.

The pulses also feed a signed step total that saturates at its limits. A processor reads this total through a read strobe, and each read clears it. One instance serves one encoder. Contact bounce is absorbed by the tracking rule: only one line is expected to chatter at a time, so a bounce moves the counter one step and then straight back.

Top module: `qdec_top`

## Requirements
- R1: In reset and directly after it, both pulse outputs are low and `step_count` is zero.
- R2: Each raw line passes through `SYNC_STAGES` (default 2) flip-flops before it is decoded. With the default setting, a pulse caused by an input change shows up after the third rising clock edge that follows the change.
- R3: Raw line A is the upper bit and B the lower bit. Both idle high (11) at a detent. The binary position is {~A, A xor B}. Clockwise rotation drives the raw sequence 11, 10, 00, 01, 11, which is binary 00, 01, 10, 11, 00.
- R4: A tracking counter at +3 (binary 011) that sees the detent code emits exactly one `cw_pulse`. This happens after a full clockwise click, and also when the click contains a reversal that is later taken back.
- R5: A tracking counter at -3 (binary 101) that sees the detent code emits exactly one `ccw_pulse`. This happens after a full counter-clockwise click, where the raw sequence is 11, 01, 00, 10, 11.
- R6: Only a change of exactly one step, up or down modulo 4, moves the tracking counter. A repeated code or a jump of two steps leaves it unchanged, and a partial turn that returns to the detent emits no pulse.
- R7: The detent code sets the tracking counter to zero whatever value it held before, including after a jump.
- R8: Each pulse lasts exactly one clock cycle, and the two pulses are never high together.
- R9: `step_count` is a signed total. Each `cw_pulse` adds one and each `ccw_pulse` subtracts one. A cycle with `rd_stb` high loads the current total into `step_count` on that edge and clears the total.
- R10: The total saturates at the largest positive and the most negative `CNT_W`-bit value. It never wraps.
- R11: A pulse that reaches the total in the same cycle as a read is not lost. It forms the starting value of the total for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_raw | input | 1 | Raw contact line A (upper Gray bit, idles high) |
| enc_b_raw | input | 1 | Raw contact line B (lower Gray bit, idles high) |
| rd_stb | input | 1 | Read strobe; captures the step total and clears it |
| cw_pulse | output | 1 | One-cycle clockwise step pulse |
| ccw_pulse | output | 1 | One-cycle counter-clockwise step pulse |
| step_count | output | CNT_W | Signed step total captured by the latest read |

## Verification
The bench drives a raw input change just after a falling edge. The first two rising edges carry the change through the synchronizer, and the third registers the pulse. The bench therefore expects the pulse on the third falling edge after the change and expects it gone on the fourth, and it checks it there exactly. The total takes in the pulse on the next rising edge, so the bench raises `rd_stb` in the pulse cycle to test the same-cycle read case. A read result is checked on the falling edge after the strobed rising edge. For multi-step scenarios the bench allows four cycles per input change, which settles every register before the pulse counts and read values are compared.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // binary quarter-step position between detents (00 = detent)
  typedef logic [1:0] quad_pos_t;

  // signed tracking counter, range -3..+3 in use
  typedef logic signed [2:0] track_cnt_t;

  localparam quad_pos_t  POS_DETENT = 2'b00;
  localparam track_cnt_t TRACK_FWD_FULL = 3'sb011;
  localparam track_cnt_t TRACK_REV_FULL = 3'sb101;
  localparam track_cnt_t TRACK_ZERO = 3'sb000;

  // raw lines idle high: invert, then Gray to binary (upper bit passes through)
  function automatic quad_pos_t raw_to_pos(input logic [1:0] raw_pair);
    logic [1:0] gray;
    gray = ~raw_pair;
    return {gray[1], gray[1] ^ gray[0]};
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] stage_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '1;
        end else if (s == 0) begin
          stage_q[s] <= din;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
    if (SYNC_STAGES > 1) begin : g_chk
      // R2: the output stage always carries the previous stage one cycle later
      assert_sync_chain_R2: assert property (@(posedge clk) disable iff (rst)
        stage_q[LAST] == $past(stage_q[LAST-1]));
    end
  endgenerate

  assign dout = stage_q[LAST];

endmodule

// File: rtl/qdec_track.sv
module qdec_track
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lines_sync,
  output logic       cw_pulse,
  output logic       ccw_pulse
);

  quad_pos_t  pos_now;
  quad_pos_t  pos_prev;
  quad_pos_t  pos_diff;
  track_cnt_t cnt_q;
  logic       step_fwd;
  logic       step_rev;
  logic       at_detent;

  always_comb begin
    pos_now   = raw_to_pos(lines_sync);
    pos_diff  = pos_now - pos_prev;
    step_fwd  = (pos_diff == 2'd1);
    step_rev  = (pos_diff == 2'd3);
    at_detent = (pos_now == POS_DETENT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_prev  <= POS_DETENT;
      cnt_q     <= TRACK_ZERO;
      cw_pulse  <= 1'b0;
      ccw_pulse <= 1'b0;
    end else begin
      pos_prev  <= pos_now;
      cw_pulse  <= at_detent && (cnt_q == TRACK_FWD_FULL);
      ccw_pulse <= at_detent && (cnt_q == TRACK_REV_FULL);
      if (at_detent) begin
        cnt_q <= TRACK_ZERO;
      end else if (step_fwd) begin
        cnt_q <= cnt_q + 3'sd1;
      end else if (step_rev) begin
        cnt_q <= cnt_q - 3'sd1;
      end
    end
  end

  // R7: the detent code always returns the tracker to zero
  assert_detent_zero_R7: assert property (@(posedge clk) disable iff (rst)
    at_detent |=> (cnt_q == TRACK_ZERO));
  // R4: a clockwise pulse only follows a +3 count
  assert_cw_from_full_R4: assert property (@(posedge clk) disable iff (rst)
    cw_pulse |-> ($past(cnt_q) == TRACK_FWD_FULL));
  // R5: a counter-clockwise pulse only follows a -3 count
  assert_ccw_from_full_R5: assert property (@(posedge clk) disable iff (rst)
    ccw_pulse |-> ($past(cnt_q) == TRACK_REV_FULL));
  // R8: pulses are one cycle wide and exclusive
  assert_cw_single_R8: assert property (@(posedge clk) disable iff (rst)
    cw_pulse |=> !cw_pulse);
  assert_ccw_single_R8: assert property (@(posedge clk) disable iff (rst)
    ccw_pulse |=> !ccw_pulse);
  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw_pulse, ccw_pulse}));
  // R6: a repeated code leaves the tracker unchanged
  assert_repeat_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!at_detent && pos_now == pos_prev) |=> $stable(cnt_q));

endmodule

// File: rtl/qdec_accum.sv
module qdec_accum #(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inc,
  input  logic                    dec,
  input  logic                    rd_stb,
  output logic signed [CNT_W-1:0] rd_data
);

  localparam logic signed [CNT_W:0] SAT_MAX = (CNT_W+1)'((1 << (CNT_W-1)) - 1);
  localparam logic signed [CNT_W:0] SAT_MIN = -(CNT_W+1)'(1 << (CNT_W-1));

  logic signed [CNT_W-1:0] total_q;
  logic signed [CNT_W:0]   base;
  logic signed [CNT_W:0]   delta;
  logic signed [CNT_W:0]   sum;
  logic signed [CNT_W-1:0] next_total;

  always_comb begin
    // a read restarts the total; a pulse in the same cycle is kept
    base  = rd_stb ? '0 : {total_q[CNT_W-1], total_q};
    delta = inc ? (CNT_W+1)'(1) : (dec ? -(CNT_W+1)'(1) : '0);
    sum   = base + delta;
    if (sum > SAT_MAX)      next_total = SAT_MAX[CNT_W-1:0];
    else if (sum < SAT_MIN) next_total = SAT_MIN[CNT_W-1:0];
    else                    next_total = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      rd_data <= '0;
    end else begin
      total_q <= next_total;
      if (rd_stb) rd_data <= total_q;
    end
  end

  // R10: no wrap from the top limit on a further increment
  assert_no_wrap_hi_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && inc && total_q == SAT_MAX[CNT_W-1:0]) |=> (total_q == SAT_MAX[CNT_W-1:0]));
  // R10: no wrap from the bottom limit on a further decrement
  assert_no_wrap_lo_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && dec && total_q == SAT_MIN[CNT_W-1:0]) |=> (total_q == SAT_MIN[CNT_W-1:0]));
  // R9: without a read the reported value holds
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

endmodule

// File: rtl/qdec_top.sv
module qdec_top #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enc_a_raw,
  input  logic                    enc_b_raw,
  input  logic                    rd_stb,
  output logic                    cw_pulse,
  output logic                    ccw_pulse,
  output logic signed [CNT_W-1:0] step_count
);

  logic [1:0] lines_sync;
  logic       cw_int;
  logic       ccw_int;

  qdec_sync #(
    .WIDTH      (2),
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({enc_a_raw, enc_b_raw}),
    .dout(lines_sync)
  );

  qdec_track track_i (
    .clk       (clk),
    .rst       (rst),
    .lines_sync(lines_sync),
    .cw_pulse  (cw_int),
    .ccw_pulse (ccw_int)
  );

  qdec_accum #(
    .CNT_W(CNT_W)
  ) accum_i (
    .clk    (clk),
    .rst    (rst),
    .inc    (cw_int),
    .dec    (ccw_int),
    .rd_stb (rd_stb),
    .rd_data(step_count)
  );

  assign cw_pulse  = cw_int;
  assign ccw_pulse = ccw_int;

  // R1: quiet outputs right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!cw_pulse && !ccw_pulse && step_count == '0));

endmodule

// File: tb/qdec_top_tb_top.sv
`timescale 1ns/1ps
module qdec_top_tb_top;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_a_raw = 1'b1;
  logic enc_b_raw = 1'b1;
  logic rd_stb = 1'b0;
  logic cw_pulse;
  logic ccw_pulse;
  logic signed [W-1:0] step_count;

  int checks = 0;
  int errors = 0;
  int cw_seen = 0;
  int ccw_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qdec_top #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .enc_a_raw(enc_a_raw), .enc_b_raw(enc_b_raw),
    .rd_stb(rd_stb), .cw_pulse(cw_pulse), .ccw_pulse(ccw_pulse),
    .step_count(step_count)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (cw_pulse) cw_seen++;
      if (ccw_pulse) ccw_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // binary position to raw line levels (R3 mapping)
  task automatic put_pos(input logic [1:0] p);
    logic [1:0] g;
    g = {p[1], p[1] ^ p[0]};
    {enc_a_raw, enc_b_raw} = ~g;
  endtask

  task automatic step_to(input logic [1:0] p);
    @(negedge clk);
    put_pos(p);
    repeat (4) @(negedge clk);
  endtask

  task automatic turn_cw();
    step_to(2'b01); step_to(2'b10); step_to(2'b11); step_to(2'b00);
  endtask

  task automatic turn_ccw();
    step_to(2'b11); step_to(2'b10); step_to(2'b01); step_to(2'b00);
  endtask

  task automatic do_read(output int val);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    val = int'(step_count);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!cw_pulse && !ccw_pulse, "R1 pulses", {cw_pulse, ccw_pulse}, 0);
    chk(step_count == 0, "R1 step_count", int'(step_count), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cw_pulse && !ccw_pulse && step_count == 0, "R1 after release",
        int'(step_count), 0);
  endtask

  task automatic t_latency();
    int v;
    step_to(2'b01); step_to(2'b10); step_to(2'b11);
    @(negedge clk);
    put_pos(2'b00);
    @(negedge clk); chk(!cw_pulse, "R2 edge1", cw_pulse, 0);
    @(negedge clk); chk(!cw_pulse, "R2 edge2", cw_pulse, 0);
    @(negedge clk); chk(cw_pulse && !ccw_pulse, "R2 R3 R4 edge3 cw", cw_pulse, 1);
    @(negedge clk); chk(!cw_pulse, "R8 width", cw_pulse, 0);
    do_read(v);
    chk(v == 1, "R9 one cw", v, 1);
  endtask

  task automatic t_ccw();
    int c0, w0, v;
    c0 = ccw_seen; w0 = cw_seen;
    turn_ccw();
    chk(ccw_seen - c0 == 1, "R5 ccw count", ccw_seen - c0, 1);
    chk(cw_seen == w0, "R8 no cw on ccw", cw_seen - w0, 0);
    do_read(v);
    chk(v == -1, "R9 one ccw", v, -1);
  endtask

  task automatic t_jump();
    int c0, w0, v;
    c0 = ccw_seen; w0 = cw_seen;
    step_to(2'b10); step_to(2'b00);
    step_to(2'b00);
    step_to(2'b01); step_to(2'b00);
    step_to(2'b01); step_to(2'b11); step_to(2'b00);
    chk(cw_seen == w0 && ccw_seen == c0, "R6 no pulse", cw_seen - w0 + ccw_seen - c0, 0);
    do_read(v);
    chk(v == 0, "R6 total", v, 0);
  endtask

  task automatic t_detent_zero();
    int c0, w0;
    c0 = ccw_seen; w0 = cw_seen;
    step_to(2'b01); step_to(2'b10); step_to(2'b00);
    turn_ccw();
    chk(ccw_seen - c0 == 1, "R7 ccw after reset to zero", ccw_seen - c0, 1);
    chk(cw_seen == w0, "R7 no cw", cw_seen - w0, 0);
  endtask

  task automatic t_reversal();
    int w0, v;
    do_read(v);
    w0 = cw_seen;
    step_to(2'b01); step_to(2'b10); step_to(2'b11); step_to(2'b10);
    step_to(2'b11); step_to(2'b00);
    chk(cw_seen - w0 == 1, "R4 reversal cw", cw_seen - w0, 1);
  endtask

  task automatic t_mixed();
    int v;
    do_read(v);
    turn_cw(); turn_cw(); turn_cw(); turn_ccw();
    do_read(v);
    chk(v == 2, "R9 net", v, 2);
    do_read(v);
    chk(v == 0, "R9 cleared", v, 0);
  endtask

  task automatic t_sat();
    int v;
    for (int i = 0; i < 9; i++) turn_cw();
    do_read(v);
    chk(v == 7, "R10 top", v, 7);
    for (int i = 0; i < 10; i++) turn_ccw();
    do_read(v);
    chk(v == -8, "R10 bottom", v, -8);
  endtask

  task automatic t_read_same();
    int v;
    step_to(2'b01); step_to(2'b10); step_to(2'b11);
    @(negedge clk);
    put_pos(2'b00);
    repeat (3) @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(step_count == 0, "R11 read before pulse", int'(step_count), 0);
    do_read(v);
    chk(v == 1, "R11 pulse kept", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_latency();
    t_ccw();
    t_jump();
    t_detent_zero();
    t_reversal();
    t_mixed();
    t_sat();
    t_read_same();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule